// File: doc/BRIEF.md
# Spacecraft Timebase and Timestamp Unit

This block keeps the on-board sample time. A free-running counter advances once per system clock. With the default widths, the clock runs at exactly 2^24 Hz, so the low 24 bits count fractions of a second and the 32 bits above them count whole seconds. The block reads a 1 Hz spacecraft clock that has no fixed relation to the system clock. It passes that input through a synchronizer and records the sample time on each rising edge. Software reads the sample time and the recorded timestamp through register-width words.

Three timing outputs come from the same counter. The first is a single-cycle interrupt pulse that repeats a power-of-two number of times per second. The second is a single-cycle buffer-swap tick at a whole-second boundary, every 1, 2 or 4 seconds. The third is a watchdog reset: it is asserted for a fixed number of cycles when software fails to write a key value in time.

The sample time is wider than one register word. A read of the low word therefore stores the upper part of the same count, which software then reads as the high word.

Top module: `sct_timebase`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output except `wdt_reset` reads zero. The watchdog counter starts from `WDT_LOAD`.
- R2: The sample time is `{seconds, subseconds}` and advances by one every clock cycle. The subsecond field is `SUB_W` bits wide. When it wraps from all ones to zero, the seconds field advances by one. `time_lo` shows the low `RD_W` bits of the current sample time.
- R3: A cycle with `lo_rd` high stores, into `time_hi`, the bits above `RD_W` of the sample time that `time_lo` shows in that same cycle. `time_hi` holds its value in every other cycle.
- R4: The 1 Hz input passes through two synchronizing flops. A rising edge first sampled high at clock edge k updates `stamp` at edge k+2, with the sample time that was current during the cycle before edge k+2. Falling edges and steady levels leave `stamp` unchanged.
- R5: Let k be the value of `irq_sel`, capped at `SUB_W`. `irq_pulse` is high for one cycle each time the subsecond field has just advanced to a multiple of 2^(SUB_W-k). This gives 2^k pulses per second. When k equals `SUB_W`, the pulse is high every cycle.
- R6: `swap_tick` is high for one cycle each time the subsecond field has just wrapped to zero and the new seconds value is divisible by the selected period. The `swap_sel` encoding is: 0 = 1 s, 1 = 2 s, 2 or 3 = 4 s.
- R7: The watchdog counts down once per cycle. It reloads `WDT_LOAD` when `kick_wr` is high with `kick_data` equal to `WDT_KEY`. If a cycle starts with the counter at zero and no valid kick arrives, `wdt_reset` goes high on the next cycle for exactly `WDT_PULSE` cycles, and the counter reloads.
- R8: A write with any `kick_data` other than `WDT_KEY` does not reload the watchdog. Expiry therefore comes `WDT_LOAD`+1 cycles after the last valid kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (2^SUB_W Hz) |
| rst | input | 1 | Synchronous active-high reset |
| pps_async | input | 1 | Spacecraft 1 Hz clock, asynchronous |
| lo_rd | input | 1 | Read strobe of the low time word; stores the high part |
| kick_wr | input | 1 | Watchdog service write strobe |
| kick_data | input | 32 | Value written with the service strobe |
| swap_sel | input | 2 | Buffer-swap period select |
| irq_sel | input | $clog2(SUB_W+1) | Interrupt rate, as log2 of pulses per second |
| time_lo | output | RD_W | Low word of the live sample time |
| time_hi | output | SUB_W+SEC_W-RD_W | Stored high part of the sample time |
| stamp | output | SUB_W+SEC_W | Sample time at the last 1 Hz rising edge |
| irq_pulse | output | 1 | Periodic interrupt pulse |
| swap_tick | output | 1 | Buffer-swap tick |
| wdt_reset | output | 1 | Watchdog reset output |

## Verification
The bench builds the block with `SUB_W`=6, `SEC_W`=10 and `RD_W`=8, so one "second" lasts 64 cycles. This brings seconds wraps, all three swap periods and the full range of interrupt rates, including the every-cycle rate, into a few thousand cycles. With those widths the high word changes every 256 cycles, so the bench can show that the stored high part matches the low word it was read with. `WDT_LOAD`=100 makes the watchdog expire and pulse several times during a run. Kicks with a wrong key, and single-cycle pulses on the 1 Hz input, are also exercised.

// File: rtl/sct_pkg.sv
package sct_pkg;

  // Swap period minus one, applied as a mask on the low seconds bits.
  // 0 -> 1 s, 1 -> 2 s, 2/3 -> 4 s.
  function automatic logic [1:0] swap_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/sct_counter.sv
module sct_counter #(
  parameter int SUB_W = 24,
  parameter int SEC_W = 32,
  parameter int RD_W  = 32,
  parameter int SEL_W = 5,
  parameter int TW    = SUB_W + SEC_W,
  parameter int HI_W  = TW - RD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lo_rd,
  input  logic [1:0]       swap_sel,
  input  logic [SEL_W-1:0] irq_sel,
  output logic [TW-1:0]    time_now,
  output logic [HI_W-1:0]  hi_q,
  output logic             irq_q,
  output logic             swap_q
);
  import sct_pkg::*;

  logic [SUB_W-1:0] sub_q, sub_inc, irq_mask;
  logic [SEC_W-1:0] sec_q, sec_inc;
  logic             wrap;

  assign sub_inc  = sub_q + SUB_W'(1);
  assign sec_inc  = sec_q + SEC_W'(1);
  assign wrap     = &sub_q;
  // Shifting out every bit gives an empty mask, which means a pulse every cycle (R5).
  assign irq_mask = {SUB_W{1'b1}} >> irq_sel;
  assign time_now = {sec_q, sub_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q  <= '0;
      sec_q  <= '0;
      hi_q   <= '0;
      irq_q  <= 1'b0;
      swap_q <= 1'b0;
    end else begin
      sub_q <= sub_inc;                                              // R2
      if (wrap) sec_q <= sec_inc;
      irq_q  <= ((sub_inc & irq_mask) == '0);                        // R5
      swap_q <= wrap && ((sec_inc[1:0] & swap_mask(swap_sel)) == 2'b00); // R6
      if (lo_rd) hi_q <= time_now[TW-1:RD_W];                        // R3
    end
  end

endmodule

// File: rtl/sct_ppsstamp.sv
module sct_ppsstamp #(
  parameter int TW     = 56,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pps_async,
  input  logic [TW-1:0] time_now,
  output logic [TW-1:0] stamp_q
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              rise;

  generate
    if (SYNC_N == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pps_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_N-2:0], pps_async};
      end
    end
  endgenerate

  assign rise = sync_q[SYNC_N-1] & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      stamp_q <= '0;
    end else begin
      prev_q <= sync_q[SYNC_N-1];
      if (rise) stamp_q <= time_now;   // R4
    end
  end

endmodule

// File: rtl/sct_watchdog.sv
module sct_watchdog #(
  parameter int          WDT_W     = 24,
  parameter int          WDT_LOAD  = 16777215,
  parameter int          WDT_PULSE = 16,
  parameter logic [31:0] WDT_KEY   = 32'hA5C3_0F96
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        kick_wr,
  input  logic [31:0] kick_data,
  output logic        wdt_q
);
  localparam int PCW = $clog2(WDT_PULSE + 1);

  logic [WDT_W-1:0] cnt_q;
  logic [PCW-1:0]   pul_q, pul_d;
  logic             kick, expire;

  assign kick   = kick_wr && (kick_data == WDT_KEY);   // R8: other values ignored
  assign expire = !kick && (cnt_q == '0);

  always_comb begin
    if (expire)            pul_d = PCW'(WDT_PULSE);
    else if (pul_q != '0)  pul_d = pul_q - PCW'(1);
    else                   pul_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= WDT_W'(WDT_LOAD);
      pul_q <= '0;
      wdt_q <= 1'b0;
    end else begin
      cnt_q <= (kick || expire) ? WDT_W'(WDT_LOAD) : cnt_q - WDT_W'(1);  // R7
      pul_q <= pul_d;
      wdt_q <= (pul_d != '0);
    end
  end

endmodule

// File: rtl/sct_timebase.sv
module sct_timebase #(
  parameter int          SUB_W     = 24,
  parameter int          SEC_W     = 32,
  parameter int          RD_W      = 32,
  parameter int          SYNC_N    = 2,
  parameter int          WDT_W     = 24,
  parameter int          WDT_LOAD  = 16777215,
  parameter int          WDT_PULSE = 16,
  parameter logic [31:0] WDT_KEY   = 32'hA5C3_0F96,
  parameter int          SEL_W     = $clog2(SUB_W + 1),
  parameter int          TW        = SUB_W + SEC_W,
  parameter int          HI_W      = TW - RD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pps_async,
  input  logic             lo_rd,
  input  logic             kick_wr,
  input  logic [31:0]      kick_data,
  input  logic [1:0]       swap_sel,
  input  logic [SEL_W-1:0] irq_sel,
  output logic [RD_W-1:0]  time_lo,
  output logic [HI_W-1:0]  time_hi,
  output logic [TW-1:0]    stamp,
  output logic             irq_pulse,
  output logic             swap_tick,
  output logic             wdt_reset
);
  logic [TW-1:0] time_now;

  sct_counter #(
    .SUB_W(SUB_W), .SEC_W(SEC_W), .RD_W(RD_W), .SEL_W(SEL_W), .TW(TW), .HI_W(HI_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .lo_rd(lo_rd), .swap_sel(swap_sel), .irq_sel(irq_sel),
    .time_now(time_now), .hi_q(time_hi), .irq_q(irq_pulse), .swap_q(swap_tick)
  );

  sct_ppsstamp #(.TW(TW), .SYNC_N(SYNC_N)) u_pps (
    .clk(clk), .rst(rst), .pps_async(pps_async), .time_now(time_now), .stamp_q(stamp)
  );

  sct_watchdog #(
    .WDT_W(WDT_W), .WDT_LOAD(WDT_LOAD), .WDT_PULSE(WDT_PULSE), .WDT_KEY(WDT_KEY)
  ) u_wdt (
    .clk(clk), .rst(rst), .kick_wr(kick_wr), .kick_data(kick_data), .wdt_q(wdt_reset)
  );

  assign time_lo = time_now[RD_W-1:0];

endmodule

// File: rtl/sct_timebase_chk.sv
module sct_timebase_chk #(
  parameter int SUB_W     = 24,
  parameter int RD_W      = 32,
  parameter int HI_W      = 24,
  parameter int SEL_W     = 5,
  parameter int WDT_PULSE = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             lo_rd,
  input logic [SEL_W-1:0] irq_sel,
  input logic [RD_W-1:0]  time_lo,
  input logic [HI_W-1:0]  time_hi,
  input logic             irq_pulse,
  input logic             swap_tick,
  input logic             wdt_reset
);
  localparam int RW = $clog2(WDT_PULSE + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)            run_q <= '0;
    else if (wdt_reset) run_q <= run_q + RW'(1);
    else                run_q <= '0;
  end

  // R2
  lo_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> time_lo == $past(time_lo) + RD_W'(1));

  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !lo_rd |=> $stable(time_hi));

  // R5
  irq_align_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> ((time_lo[SUB_W-1:0] & ({SUB_W{1'b1}} >> $past(irq_sel))) == '0));

  // R6
  swap_align_chk: assert property (@(posedge clk) disable iff (rst)
    swap_tick |-> time_lo[SUB_W-1:0] == '0);

  // R7
  wdt_max_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_reset |-> run_q < RW'(WDT_PULSE));

  // R7
  wdt_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_reset) |-> run_q == RW'(WDT_PULSE));

endmodule

bind sct_timebase sct_timebase_chk #(
  .SUB_W(SUB_W), .RD_W(RD_W), .HI_W(HI_W), .SEL_W(SEL_W), .WDT_PULSE(WDT_PULSE)
) u_chk (
  .clk(clk), .rst(rst), .lo_rd(lo_rd), .irq_sel(irq_sel), .time_lo(time_lo),
  .time_hi(time_hi), .irq_pulse(irq_pulse), .swap_tick(swap_tick), .wdt_reset(wdt_reset)
);

// File: tb/sct_timebase_test.sv
module sct_timebase_test;
  localparam int SUB_W = 6, SEC_W = 10, RD_W = 8;
  localparam int TW = SUB_W + SEC_W, HI_W = TW - RD_W;
  localparam int SEL_W = $clog2(SUB_W + 1);
  localparam int LOAD = 100, PULSE = 16;
  localparam logic [31:0] KEY = 32'hA5C3_0F96;

  logic clk = 1'b0, rst = 1'b1, pps_async = 1'b0, lo_rd = 1'b0, kick_wr = 1'b0;
  logic [31:0] kick_data = '0;
  logic [1:0] swap_sel = '0;
  logic [SEL_W-1:0] irq_sel = '0;
  logic [RD_W-1:0] time_lo;
  logic [HI_W-1:0] time_hi;
  logic [TW-1:0] stamp;
  logic irq_pulse, swap_tick, wdt_reset;

  int tests = 0, fails = 0;
  bit done = 0, started = 0;

  always #10 clk = ~clk;

  sct_timebase #(.SUB_W(SUB_W), .SEC_W(SEC_W), .RD_W(RD_W), .WDT_W(8),
                 .WDT_LOAD(LOAD), .WDT_PULSE(PULSE), .WDT_KEY(KEY)) uut (
    .clk(clk), .rst(rst), .pps_async(pps_async), .lo_rd(lo_rd), .kick_wr(kick_wr),
    .kick_data(kick_data), .swap_sel(swap_sel), .irq_sel(irq_sel), .time_lo(time_lo),
    .time_hi(time_hi), .stamp(stamp), .irq_pulse(irq_pulse), .swap_tick(swap_tick),
    .wdt_reset(wdt_reset));

  // Behavioural reference model
  int t = 0, hi_m = 0, stamp_m = 0, wcnt = LOAD, pul = 0;
  bit s1 = 0, s2 = 0, s3 = 0, irq_m = 0, swap_m = 0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      t = 0; hi_m = 0; stamp_m = 0; wcnt = LOAD; pul = 0;
      s1 = 0; s2 = 0; s3 = 0; irq_m = 0; swap_m = 0;
    end else begin
      int sub_old, sec_new, k, per;
      sub_old = t % (1 << SUB_W);
      sec_new = (t / (1 << SUB_W) + 1) % (1 << SEC_W);
      k = (int'(irq_sel) > SUB_W) ? SUB_W : int'(irq_sel);
      irq_m = (((sub_old + 1) % (1 << (SUB_W - k))) == 0);
      per = (swap_sel == 0) ? 1 : (swap_sel == 1) ? 2 : 4;
      swap_m = (sub_old == (1 << SUB_W) - 1) && (sec_new % per == 0);
      if (lo_rd) hi_m = t >> RD_W;
      if (s2 && !s3) stamp_m = t;
      s3 = s2; s2 = s1; s1 = pps_async;
      t = (t + 1) % (1 << TW);
      if (pul > 0) pul--;
      if (kick_wr && kick_data == KEY) wcnt = LOAD;
      else if (wcnt == 0) begin wcnt = LOAD; pul = PULSE; end
      else wcnt--;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 time_lo", time_lo, t % (1 << RD_W));
      chk("R3 time_hi", time_hi, hi_m);
      chk("R4 stamp", stamp, stamp_m);
      chk("R5 irq_pulse", irq_pulse, irq_m);
      chk("R6 swap_tick", swap_tick, swap_m);
      chk("R7 wdt_reset", wdt_reset, pul != 0);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 time_lo", time_lo, 0);
    chk("R1 stamp", stamp, 0);
    chk("R1 irq/swap/wdt", {irq_pulse, swap_tick, wdt_reset}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle", {time_hi, irq_pulse, swap_tick}, 0);
    for (int i = 0; i < 3200; i++) begin
      lo_rd     = (i % 7 == 3);
      pps_async = ((i / 37) % 2 == 1) || (i % 151 == 0);
      irq_sel   = SEL_W'((i / 400) % 8);
      swap_sel  = 2'((i / 700) % 4);
      kick_wr   = (i % 90 == 5) && !(i >= 1500 && i < 1800);
      kick_data = (i % 270 == 95) ? 32'h1234_5678 : KEY;
      @(negedge clk);
    end
    // R8: wrong keys do not reload; expiry LOAD+1 cycles after the valid kick
    lo_rd = 0; kick_wr = 1; kick_data = KEY;
    @(negedge clk);
    kick_wr = 0;
    for (int j = 0; j < LOAD; j++) begin
      kick_wr   = (j % 10 == 4);
      kick_data = KEY ^ 32'(j + 1);
      @(negedge clk);
    end
    kick_wr = 0;
    chk("R8 before expiry", wdt_reset, 0);
    @(negedge clk);
    chk("R8 expiry despite wrong keys", wdt_reset, 1);
    repeat (PULSE + 4) @(negedge clk);
    finish_run();
  end

endmodule